// File: doc/BRIEF.md
# Masked Four-Source Priority Interrupt Controller

This block collects interrupt requests from four sources, holds them in a pending register, and gates them with a programmable enable mask. It resolves the surviving requests with a fixed priority order into a 2-bit source code. A software-controlled master enable decides whether the combined request reaches the processor as a single interrupt line.

Software uses a small command port. One command loads the mask, one clears chosen pending bits, and two commands turn the master enable on or off. The processor answers the interrupt line with an acknowledge. On the rising edge of the acknowledge, the block captures the winning source code into an 8-bit vector and presents it on a data output with its own output-enable, which stands in for a tri-state buffer. The same acknowledge edge drops the master enable, so no further interrupt is raised until software turns it back on.

Top module: `mpic_top`

## Requirements
- R1: After synchronous reset, the pending register, the mask and the master enable are all zero, and `irq_out`, `vec_oe` and `vec_out` read 0.
- R2: A 1 on `req_in[i]` at a clock edge sets pending bit i, and the bit stays set after the input drops. Command `cmd_op`=2 (clear) clears every pending bit whose `cmd_arg` bit is 1. When a request and a clear hit the same bit on the same edge, the request wins.
- R3: Command `cmd_op`=1 loads `cmd_arg` into the mask, where a mask bit of 1 enables its source. A masked-off pending request produces no interrupt and takes no part in priority. The request stays pending and takes effect once it is unmasked.
- R4: Among the enabled pending requests, the lowest index wins. Source 0 gives code 00, source 1 gives 01, source 2 gives 10 and source 3 gives 11. With no enabled pending request, the code is 11.
- R5: `irq_out` is a register. After each clock edge it equals the master enable AND the OR of the enabled pending bits, using the values that edge produced.
- R6: Command `cmd_op`=3 sets the master enable and `cmd_op`=4 clears it. Opcodes 0, 5, 6 and 7 change nothing.
- R7: On the first edge at which `intack` is high, `vec_out` takes the value `{6'b0, code}` and `vec_oe` becomes 1. After any edge at which `intack` is low, `vec_oe` is 0 and `vec_out` is 0.
- R8: The first edge with `intack` high clears the master enable, overriding an enable command on the same edge, so `irq_out` is 0 after that edge.
- R9: While `intack` stays high, `vec_out` holds the captured code even if requests, clears or mask writes change the enabled pending set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | 4 | Request lines, index 0 has the highest priority |
| cmd_op | input | 3 | Command: 0 none, 1 load mask, 2 clear pending, 3 enable on, 4 enable off |
| cmd_arg | input | 4 | Mask value or clear bits for the command |
| intack | input | 1 | Interrupt acknowledge from the processor |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector address, driven while `vec_oe` is 1 |
| vec_oe | output | 1 | Output-enable for the vector bus |

## Verification
Pending bits and the mask have no port of their own, so an error in them shows up in two ways. `irq_out` is wrong on the very next edge, and the vector captured at the next acknowledge is wrong. The bench therefore follows every stimulus with acknowledges that read the winning code. A master enable stuck high shows up as `irq_out` staying high one edge after an acknowledge or a disable command. A capture that is not held shows up as `vec_out` moving during a long acknowledge while requests change underneath it.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_MASK = 3'd1,
    OP_CLR  = 3'd2,
    OP_ION  = 3'd3,
    OP_IOF  = 3'd4
  } mpic_op_e;
endpackage

// File: rtl/mpic_req_bank.sv
module mpic_req_bank #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_in,
  input  logic [2:0]      cmd_op,
  input  logic [NSRC-1:0] cmd_arg,
  output logic [NSRC-1:0] act_q,
  output logic            any_d,
  output logic [NSRC-1:0] pend_q
);
  import mpic_pkg::*;

  logic [NSRC-1:0] pend_d, mask_d, mask_q, clr_bits;

  always_comb begin
    clr_bits = (cmd_op == OP_CLR) ? cmd_arg : '0;
    pend_d   = (pend_q & ~clr_bits) | req_in;   // a new request beats a clear
    mask_d   = (cmd_op == OP_MASK) ? cmd_arg : mask_q;
    any_d    = |(pend_d & mask_d);
    act_q    = pend_q & mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/mpic_prio_enc.sv
module mpic_prio_enc #(
  parameter int NSRC = 4,
  localparam int CW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] act,
  output logic [CW-1:0]   code
);
  always_comb begin
    code = CW'(NSRC - 1);
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act[i]) code = CW'(i);
    end
  end
endmodule

// File: rtl/mpic_vec_drv.sv
module mpic_vec_drv #(
  parameter int CW = 2,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          intack,
  input  logic [CW-1:0] code,
  output logic          ack_rise,
  output logic [VW-1:0] vec_out,
  output logic          vec_oe
);
  logic ack_q;

  assign ack_rise = intack & ~ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      vec_oe  <= 1'b0;
      vec_out <= '0;
    end else begin
      ack_q  <= intack;
      vec_oe <= intack;
      if (ack_rise)    vec_out <= VW'(code);
      else if (!intack) vec_out <= '0;
    end
  end
endmodule

// File: rtl/mpic_top.sv
module mpic_top #(
  parameter int NSRC = 4,
  parameter int VW   = 8,
  localparam int CW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_in,
  input  logic [2:0]      cmd_op,
  input  logic [NSRC-1:0] cmd_arg,
  input  logic            intack,
  output logic            irq_out,
  output logic [VW-1:0]   vec_out,
  output logic            vec_oe
);
  import mpic_pkg::*;

  logic [NSRC-1:0] act_q, pend_q;
  logic            any_d, ack_rise, ien_q, ien_d;
  logic [CW-1:0]   code;

  mpic_req_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst(rst), .req_in(req_in), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .act_q(act_q), .any_d(any_d), .pend_q(pend_q)
  );

  mpic_prio_enc #(.NSRC(NSRC)) u_enc (.act(act_q), .code(code));

  mpic_vec_drv #(.CW(CW), .VW(VW)) u_vec (
    .clk(clk), .rst(rst), .intack(intack), .code(code),
    .ack_rise(ack_rise), .vec_out(vec_out), .vec_oe(vec_oe)
  );

  always_comb begin
    ien_d = ien_q;
    if (cmd_op == OP_ION) ien_d = 1'b1;
    if (cmd_op == OP_IOF) ien_d = 1'b0;
    if (ack_rise)         ien_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q   <= 1'b0;
      irq_out <= 1'b0;
    end else begin
      ien_q   <= ien_d;
      irq_out <= ien_d & any_d;
    end
  end
endmodule

// File: rtl/mpic_checker.sv
module mpic_checker #(
  parameter int NSRC = 4,
  parameter int VW   = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] req_in,
  input logic [2:0]      cmd_op,
  input logic            intack,
  input logic            irq_out,
  input logic [VW-1:0]   vec_out,
  input logic            vec_oe,
  input logic [NSRC-1:0] pend_q,
  input logic            ien_q
);
  p_req_latch_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(req_in)) == $past(req_in)));

  p_iof_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == 3'd4 && !intack) |=> (!irq_out && !ien_q));

  p_oe_tracks_ack_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (vec_oe == $past(intack)));

  p_quiet_bus_r7: assert property (@(posedge clk) disable iff (rst)
    !vec_oe |-> (vec_out == '0));

  p_ack_drops_irq_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(intack) |=> (!irq_out && !ien_q));

  p_vec_held_r9: assert property (@(posedge clk) disable iff (rst)
    (intack && vec_oe) |=> (!intack || $stable(vec_out)));

  p_irq_needs_ien_r5: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ien_q);
endmodule

bind mpic_top mpic_checker #(.NSRC(NSRC), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .req_in(req_in), .cmd_op(cmd_op), .intack(intack),
  .irq_out(irq_out), .vec_out(vec_out), .vec_oe(vec_oe),
  .pend_q(pend_q), .ien_q(ien_q)
);

// File: tb/mpic_top_test.sv
module mpic_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req_in = '0;
  logic [2:0] cmd_op = '0;
  logic [3:0] cmd_arg = '0;
  logic       intack = 1'b0;
  logic       irq_out, vec_oe;
  logic [7:0] vec_out;

  int n_chk = 0;
  int n_bad = 0;

  logic [3:0] m_pend, m_mask;
  logic       m_ien, m_ackp, m_irq, m_oe;
  logic [7:0] m_vec;

  always #5 clk = ~clk;

  mpic_top uut (
    .clk(clk), .rst(rst), .req_in(req_in), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .intack(intack), .irq_out(irq_out), .vec_out(vec_out), .vec_oe(vec_oe)
  );

  // priority equations for four sources, source 0 highest
  function automatic logic [1:0] enc(input logic [3:0] m);
    logic x, y;
    x = ~m[0] & ~m[1];
    y = (~m[0] & m[1]) | (~m[0] & ~m[2]);
    return {x, y};
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] r, input logic [2:0] op, input logic [3:0] a,
                     input logic k, input string tag);
    logic [3:0] clr;
    logic rise;
    req_in = r; cmd_op = op; cmd_arg = a; intack = k;
    rise  = k & ~m_ackp;
    clr   = (op == 3'd2) ? a : 4'd0;
    if (rise)       m_vec = {6'b0, enc(m_pend & m_mask)};
    else if (!k)    m_vec = 8'd0;
    m_oe  = k;
    m_pend = (m_pend & ~clr) | r;
    if (op == 3'd1) m_mask = a;
    if (op == 3'd3) m_ien = 1'b1;
    if (op == 3'd4) m_ien = 1'b0;
    if (rise)       m_ien = 1'b0;
    m_ackp = k;
    m_irq  = m_ien & (|(m_pend & m_mask));
    @(posedge clk);
    @(negedge clk);
    check(tag, "irq_out", {7'b0, irq_out}, {7'b0, m_irq});
    check(tag, "vec_oe",  {7'b0, vec_oe},  {7'b0, m_oe});
    check(tag, "vec_out", vec_out, m_vec);
  endtask

  task automatic ack_read(input string tag);
    cyc(4'd0, 3'd0, 4'd0, 1'b1, tag);
    cyc(4'd0, 3'd0, 4'd0, 1'b1, tag);
    cyc(4'd0, 3'd0, 4'd0, 1'b0, tag);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_pend = 0; m_mask = 0; m_ien = 0; m_ackp = 0; m_irq = 0; m_oe = 0; m_vec = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    check("R1", "irq_out", {7'b0, irq_out}, 8'd0);
    check("R1", "vec_oe",  {7'b0, vec_oe},  8'd0);
    check("R1", "vec_out", vec_out, 8'd0);
    // R1: mask reset to zero, so an enabled request raises nothing
    cyc(4'b1111, 3'd3, 4'd0, 1'b0, "R1");
    cyc(4'd0, 3'd0, 4'd0, 1'b0, "R1");
    // R3: unmask source 3 only -> irq, code 11
    cyc(4'd0, 3'd1, 4'b1000, 1'b0, "R3");
    ack_read("R3");
    // R4: each single source, and the empty case
    for (int s = 0; s < 4; s++) begin
      cyc(4'd0, 3'd2, 4'b1111, 1'b0, "R4");
      cyc(4'd0, 3'd1, 4'b1111, 1'b0, "R4");
      cyc(4'(1 << s), 3'd3, 4'd0, 1'b0, "R4");
      ack_read("R4");
    end
    cyc(4'd0, 3'd2, 4'b1111, 1'b0, "R4");
    ack_read("R4");
    // R4: mixed patterns
    cyc(4'b1100, 3'd3, 4'd0, 1'b0, "R4");
    ack_read("R4");
    cyc(4'b0010, 3'd3, 4'd0, 1'b0, "R4");
    ack_read("R4");
    // R2: request and clear on the same edge, request wins
    cyc(4'd0, 3'd2, 4'b1111, 1'b0, "R2");
    cyc(4'b0001, 3'd2, 4'b0001, 1'b0, "R2");
    cyc(4'd0, 3'd3, 4'd0, 1'b0, "R2");
    ack_read("R2");
    // R2: selective clear exposes next source
    cyc(4'd0, 3'd2, 4'b0001, 1'b0, "R2");
    cyc(4'b0100, 3'd3, 4'd0, 1'b0, "R2");
    ack_read("R2");
    // R6: enable off, unused opcodes ignored
    cyc(4'd0, 3'd3, 4'd0, 1'b0, "R6");
    cyc(4'd0, 3'd4, 4'd0, 1'b0, "R6");
    cyc(4'd0, 3'd5, 4'b1111, 1'b0, "R6");
    cyc(4'd0, 3'd6, 4'b0000, 1'b0, "R6");
    cyc(4'd0, 3'd7, 4'b1111, 1'b0, "R6");
    cyc(4'd0, 3'd3, 4'd0, 1'b0, "R6");
    // R8: acknowledge beats enable-on on the same edge
    cyc(4'd0, 3'd3, 4'd0, 1'b1, "R8");
    cyc(4'd0, 3'd0, 4'd0, 1'b1, "R8");
    cyc(4'd0, 3'd0, 4'd0, 1'b0, "R8");
    // R9: long acknowledge with changing requests, clears and mask
    cyc(4'd0, 3'd3, 4'd0, 1'b0, "R9");
    cyc(4'd0, 3'd0, 4'd0, 1'b1, "R9");
    cyc(4'b0001, 3'd0, 4'd0, 1'b1, "R9");
    cyc(4'd0, 3'd2, 4'b1111, 1'b1, "R9");
    cyc(4'd0, 3'd1, 4'b0001, 1'b1, "R9");
    cyc(4'b1000, 3'd3, 4'd0, 1'b1, "R9");
    cyc(4'd0, 3'd0, 4'd0, 1'b0, "R7");
    // R5/R7: random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] r, a;
      logic [2:0] op;
      logic k;
      r  = (($urandom % 4) == 0) ? 4'($urandom) : 4'd0;
      op = (($urandom % 3) == 0) ? 3'($urandom) : 3'd0;
      a  = 4'($urandom);
      k  = ($urandom % 5) == 0 ? 1'b1 : (m_ackp && ($urandom % 2) == 0);
      cyc(r, op, a, k, "R5/R7");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule